// File: doc/BRIEF.md
# Threshold-Gated Read Stream Buffer

This block sits between a bus read engine and a framed streaming consumer. The read engine pushes data words into a synchronous FIFO. Each word carries a last-word marker and a remainder field that says which byte lanes are valid. The consumer sees the words through an active-low handshake. The source side offers data only once enough words are buffered to keep a burst flowing without stalls. It also offers data as soon as the final word of a requested transfer is already inside. This avoids starving the consumer mid-packet when the producer is slower than the consumer.

Once a burst has begun, the buffer keeps offering words while it holds any. The occupancy check is re-armed only after the last-word marker has been handed over, or after the buffer has drained empty. The remainder field travels with its word and comes out unchanged. It can be sized for encoded form, which is a byte-lane index, or for mask form, which is one bit per lane. Occupancy is reported on a read-count bus. That bus can be made narrower than the full count, in which case it carries the upper bits of the count. A threshold above depth minus 16 is rejected at elaboration when the depth is 16 or more.

Top module: `gated_read_fifo`

## Requirements
- R1: Words come out in the order they were written, and each keeps its data and remainder values unchanged.
- R2: While no burst is active and no marked last word is stored, `out_src_rdy_n` stays high until the occupancy reaches `THRESH`. It goes low from the cycle in which occupancy is at least `THRESH`.
- R3: After a word without the last-word marker has been handed over, `out_src_rdy_n` stays low on every cycle the buffer is non-empty. The threshold check applies again after a marked word is handed over, or one cycle after the buffer is seen empty.
- R4: While at least one stored word carries the last-word marker (`wr_eop`=1 at write), `out_src_rdy_n` is low whenever the buffer is non-empty, whatever the occupancy.
- R5: A word is handed over, and removed, on each clock edge where `out_src_rdy_n` and `out_dst_rdy_n` are both low.
- R6: `out_eof_n` is low exactly when a word is offered and that word carries the last-word marker.
- R7: `out_sof_n` is low exactly when a word is offered and it is the first word after reset or the first word after a marked word was handed over.
- R8: With `RDCNT_W` equal to log2(`DEPTH`)+1, `rd_cnt` equals the number of stored words, from 0 up to and including `DEPTH`.
- R9: With a narrower `RDCNT_W`, `rd_cnt` carries the top `RDCNT_W` bits of the full count, which is the count shifted right by log2(`DEPTH`)+1-`RDCNT_W`.
- R10: `wr_full` is high exactly when `DEPTH` words are stored. A write on such a cycle is dropped and stores nothing.
- R11: Synchronous active-high reset empties the buffer, clears any pending last-word release, re-arms the first-word flag, and drives `out_src_rdy_n`, `out_sof_n` and `out_eof_n` high.
- R12: The remainder ports are log2(`DATA_W`/8) bits wide (minimum 1) when `REM_CODING`=1 (encoded), and `DATA_W`/8 bits wide when `REM_CODING`=2 (mask).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request from the read engine |
| wr_data | input | DATA_W | Word to store |
| wr_rem | input | REM_W | Valid-byte field stored with the word |
| wr_eop | input | 1 | Marks the last word of a requested transfer |
| wr_full | output | 1 | Buffer holds DEPTH words |
| out_data | output | DATA_W | Word offered to the consumer |
| out_rem | output | REM_W | Valid-byte field of the offered word |
| out_src_rdy_n | output | 1 | Active-low: a word is offered |
| out_dst_rdy_n | input | 1 | Active-low: the consumer accepts |
| out_sof_n | output | 1 | Active-low start of frame |
| out_eof_n | output | 1 | Active-low end of frame |
| rd_cnt | output | RDCNT_W | Occupancy, most significant bits first |

## Verification
The bench builds the main instance with 32-bit data, a depth of 32, a threshold of 12, mask-form remainder and a full 6-bit count. With these values the bench can hold the buffer below the threshold long enough to observe gating, release a short packet through the last-word override, and fill all 32 places to test full backpressure. A second instance runs on the same stimulus with encoded 2-bit remainder and a 3-bit count. That instance exercises the upper-bits count and the encoded remainder width against the same occupancy.

// File: rtl/rfq_pkg.sv
package rfq_pkg;

    localparam int REM_ENCODED = 1;
    localparam int REM_MASK    = 2;

    typedef enum logic {
        GATE_ARMED     = 1'b0,
        GATE_STREAMING = 1'b1
    } gate_e;

    function automatic int lanes_of(input int data_w);
        return data_w / 8;
    endfunction

    function automatic int rem_width(input int data_w, input int coding);
        int w;
        if (coding == REM_ENCODED) w = $clog2(lanes_of(data_w));
        else                       w = lanes_of(data_w);
        return (w < 1) ? 1 : w;
    endfunction

    function automatic int count_width(input int depth);
        return $clog2(depth) + 1;
    endfunction

    function automatic int addr_width(input int depth);
        return (depth <= 2) ? 1 : $clog2(depth);
    endfunction

endpackage

// File: rtl/rfq_store.sv
module rfq_store import rfq_pkg::*; #(
    parameter int WIDTH = 37,
    parameter int DEPTH = 32,
    localparam int CW   = count_width(DEPTH),
    localparam int AW   = addr_width(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign dout  = mem[rptr];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);                                  // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);                                  // R10
    AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!push && !pop) |=> $stable(count));              // R8

endmodule

// File: rtl/rfq_gate.sv
module rfq_gate import rfq_pkg::*; #(
    parameter int DEPTH  = 32,
    parameter int THRESH = 12,
    localparam int CW    = count_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] count,
    input  logic          empty,
    input  logic          push_eop,
    input  logic          pop,
    input  logic          head_eop,
    output logic          valid,
    output logic          first
);

    gate_e         state;
    logic [CW-1:0] eop_pend;
    logic          deep_enough;

    assign deep_enough = (count >= CW'(THRESH));
    assign valid = !empty &&
                   ((state == GATE_STREAMING) || deep_enough || (eop_pend != '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= GATE_ARMED;
            first    <= 1'b1;
            eop_pend <= '0;
        end else begin
            eop_pend <= eop_pend + CW'(push_eop) - CW'(pop && head_eop);
            if (pop && head_eop) state <= GATE_ARMED;
            else if (empty)      state <= GATE_ARMED;
            else if (pop)        state <= GATE_STREAMING;
            if (pop) first <= head_eop;
        end
    end

    AST_VALID_HELD: assert property (@(posedge clk) disable iff (rst)
        (valid && !pop) |=> valid);                       // R3
    AST_GATE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> (deep_enough || eop_pend != '0)); // R2
    AST_EOP_TRACKED: assert property (@(posedge clk) disable iff (rst)
        (pop && head_eop) |-> (eop_pend != '0));          // R4

endmodule

// File: rtl/gated_read_fifo.sv
module gated_read_fifo import rfq_pkg::*; #(
    parameter int DATA_W     = 32,
    parameter int DEPTH      = 32,
    parameter int THRESH     = 12,
    parameter int REM_CODING = REM_MASK,
    parameter int RDCNT_W    = count_width(DEPTH),
    localparam int REM_W     = rem_width(DATA_W, REM_CODING),
    localparam int CW        = count_width(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [REM_W-1:0]   wr_rem,
    input  logic               wr_eop,
    output logic               wr_full,
    output logic [DATA_W-1:0]  out_data,
    output logic [REM_W-1:0]   out_rem,
    output logic               out_src_rdy_n,
    input  logic               out_dst_rdy_n,
    output logic               out_sof_n,
    output logic               out_eof_n,
    output logic [RDCNT_W-1:0] rd_cnt
);

    typedef struct packed {
        logic              eop;
        logic [REM_W-1:0]  rem;
        logic [DATA_W-1:0] data;
    } entry_t;

    localparam int EW = $bits(entry_t);

    generate
        if (DEPTH >= 16 && THRESH > DEPTH - 16) begin : g_bad_thresh
            $error("THRESH must not exceed DEPTH-16");
        end
        if (RDCNT_W < 1 || RDCNT_W > CW) begin : g_bad_cnt
            $error("RDCNT_W out of range");
        end
        if (REM_CODING != REM_ENCODED && REM_CODING != REM_MASK) begin : g_bad_code
            $error("REM_CODING must be 1 or 2");
        end
    endgenerate

    entry_t        wr_ent, head;
    logic [CW-1:0] count;
    logic          full, empty, push, pop, valid, first;

    assign wr_ent = '{eop: wr_eop, rem: wr_rem, data: wr_data};
    assign push   = wr_en && !full;
    assign pop    = valid && !out_dst_rdy_n;

    rfq_store #(.WIDTH(EW), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .din   (wr_ent),
        .dout  (head),
        .count (count),
        .full  (full),
        .empty (empty)
    );

    rfq_gate #(.DEPTH(DEPTH), .THRESH(THRESH)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .count    (count),
        .empty    (empty),
        .push_eop (push && wr_eop),
        .pop      (pop),
        .head_eop (head.eop),
        .valid    (valid),
        .first    (first)
    );

    assign wr_full       = full;
    assign out_data      = head.data;
    assign out_rem       = head.rem;
    assign out_src_rdy_n = !valid;
    assign out_sof_n     = !(valid && first);
    assign out_eof_n     = !(valid && head.eop);
    assign rd_cnt        = count[CW-1 -: RDCNT_W];

    AST_EOF_ONLY_OFFERED: assert property (@(posedge clk) disable iff (rst)
        !out_eof_n |-> !out_src_rdy_n);                   // R6
    AST_SOF_AFTER_EOP: assert property (@(posedge clk) disable iff (rst)
        (!out_src_rdy_n && !out_dst_rdy_n && !out_eof_n)
        |=> (out_src_rdy_n || !out_sof_n));               // R7

endmodule

// File: tb/tb_gated_read_fifo.sv
module tb_gated_read_fifo;

    localparam int DATA_W = 32;
    localparam int DEPTH  = 32;
    localparam int THRESH = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_eop = 1'b0, dst_rdy_n = 1'b1;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_rem = '0;

    logic        wr_full, src_rdy_n, sof_n, eof_n;
    logic [31:0] out_data;
    logic [3:0]  out_rem;
    logic [5:0]  rd_cnt;

    logic        n_full, n_src_rdy_n, n_sof_n, n_eof_n;
    logic [31:0] n_data;
    logic [1:0]  n_rem;
    logic [2:0]  n_cnt;

    always #2 clk = ~clk;

    gated_read_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .THRESH(THRESH),
                      .REM_CODING(2), .RDCNT_W(6)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_rem(wr_rem),
        .wr_eop(wr_eop), .wr_full(wr_full), .out_data(out_data), .out_rem(out_rem),
        .out_src_rdy_n(src_rdy_n), .out_dst_rdy_n(dst_rdy_n), .out_sof_n(sof_n),
        .out_eof_n(eof_n), .rd_cnt(rd_cnt));

    gated_read_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .THRESH(THRESH),
                      .REM_CODING(1), .RDCNT_W(3)) dut_n (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_rem(wr_rem[1:0]),
        .wr_eop(wr_eop), .wr_full(n_full), .out_data(n_data), .out_rem(n_rem),
        .out_src_rdy_n(n_src_rdy_n), .out_dst_rdy_n(dst_rdy_n), .out_sof_n(n_sof_n),
        .out_eof_n(n_eof_n), .rd_cnt(n_cnt));

    typedef struct { logic [31:0] d; logic [3:0] r; logic e; } ent_t;
    ent_t q[$];
    int   eop_pend = 0;
    bit   strm = 0, first = 1;
    int   checks = 0, errors = 0;
    bit   done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_valid();
        return q.size() > 0 && (strm || q.size() >= THRESH || eop_pend > 0);
    endfunction

    task automatic compare();
        bit ev = exp_valid();
        int n  = q.size();
        chk(src_rdy_n == !ev, "R2/R3/R4", "src_rdy_n", src_rdy_n, !ev);
        chk(sof_n == !(ev && first), "R7", "sof_n", sof_n, !(ev && first));
        chk(eof_n == !(ev && n > 0 && q[0].e), "R6", "eof_n", eof_n,
            !(ev && n > 0 && q[0].e));
        chk(rd_cnt == 6'(n), "R8", "rd_cnt", rd_cnt, n);
        chk(wr_full == (n == DEPTH), "R10", "wr_full", wr_full, n == DEPTH);
        chk(n_cnt == 3'(n >> 3), "R9", "narrow rd_cnt", n_cnt, n >> 3);
        chk(n_src_rdy_n == !ev, "R12", "narrow src_rdy_n", n_src_rdy_n, !ev);
        if (ev) begin
            chk(out_data == q[0].d, "R1 R5", "out_data", out_data, q[0].d);
            chk(out_rem == q[0].r, "R1", "out_rem", out_rem, q[0].r);
            chk(n_rem == q[0].r[1:0], "R12", "encoded rem", n_rem, q[0].r[1:0]);
        end
    endtask

    task automatic step(input int p_wr, input int p_eop, input int p_rdy);
        bit ev, wr, xf, he;
        int n;
        @(negedge clk);
        compare();
        wr_en     = ($urandom % 100) < p_wr;
        wr_data   = $urandom;
        wr_rem    = 4'($urandom);
        wr_eop    = ($urandom % 100) < p_eop;
        dst_rdy_n = !(($urandom % 100) < p_rdy);
        n  = q.size();
        ev = exp_valid();
        wr = wr_en && n < DEPTH;
        xf = ev && !dst_rdy_n;
        he = (n > 0) ? q[0].e : 1'b0;
        if (xf && he)    strm = 0;
        else if (n == 0) strm = 0;
        else if (xf)     strm = 1;
        if (xf) first = he;
        if (wr && wr_eop) eop_pend++;
        if (xf && he)     eop_pend--;
        if (xf) void'(q.pop_front());
        if (wr) q.push_back('{d: wr_data, r: wr_rem, e: wr_eop});
    endtask

    task automatic run(input int cyc, input int p_wr, input int p_eop, input int p_rdy);
        for (int i = 0; i < cyc; i++) step(p_wr, p_eop, p_rdy);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: state right after reset
        chk(src_rdy_n == 1'b1, "R11", "src_rdy_n", src_rdy_n, 1);
        chk(sof_n == 1'b1 && eof_n == 1'b1, "R11", "sof_n/eof_n", {sof_n, eof_n}, 2'b11);
        chk(rd_cnt == 0, "R11", "rd_cnt", rd_cnt, 0);
        chk(wr_full == 1'b0, "R11", "wr_full", wr_full, 0);

        run(8, 100, 0, 100);    // R2: below threshold, nothing offered
        run(6, 100, 0, 100);    // R2: crosses threshold
        run(25, 0, 0, 100);     // R3: drain while streaming
        run(3, 100, 0, 100);    // R4: short packet, then marked word
        run(1, 100, 100, 100);
        run(10, 0, 0, 100);
        run(40, 100, 0, 0);     // R10: fill, extra writes dropped
        run(45, 0, 0, 100);
        run(300, 50, 10, 70);
        run(300, 90, 3, 30);
        run(300, 30, 20, 90);
        run(300, 70, 0, 50);
        run(60, 0, 0, 100);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule